// File: doc/BRIEF.md
# Floating-Point Sub-Stage Issue Scheduler

This block decides when a floating-point operation may start in a unit built from eight shared sub-stages: unpack (U), operand shift (S), mantissa add (A), rounding (R), exception test (E), multiplier first stage (M), multiplier second stage (N) and divide iteration (D). Each operation has a fixed cycle-by-cycle reservation pattern. Multiply and divide finish on the adder's A and R hardware, so a long operation can block a short one several cycles after it started, and a single busy flag per unit is not enough.

A reservation table holds one bit per sub-stage per future cycle. It also holds a ninth column for the single result slot, so that two operations never finish in the same cycle. A request is accepted in the cycle it is presented if its whole pattern fits into free bits; otherwise stall is raised and nothing is reserved. The table shifts by one row each clock. The current row drives the per-stage busy flags. When an operation reaches its final cycle, the block pulses done together with the tag that was supplied at issue.

A two-state control machine tracks the table. In ST_EMPTY no reservation exists and any legal request is accepted. In ST_ACTIVE the request's pattern is checked against the table. The transition EMPTY_TO_ACTIVE happens on an accept. ACTIVE_TO_EMPTY happens when the last reservation shifts out with no new accept. ACTIVE_HOLD covers every other cycle while reservations remain.

Top module: `fpsched_top`

## Requirements
- R1: After reset, busy is all zero and done is low, and the first legal request is accepted.
- R2: Opcodes are ADD=0, SUB=1, MUL=2, DIV=3, NEG=4, ABS=5, CMP=6. Busy bits are U=0, S=1, A=2, R=3, E=4, M=5, N=6, D=7. A request accepted in cycle t shows busy[U] in cycle t+1. SUB behaves exactly as ADD.
- R3: ADD/SUB occupy, from cycle t+1 on: {U}, {S,A}, {A,R}, {R,S} (four cycles).
- R4: MUL occupies {U}, {E,M}, {M}, {M}, {M}, {N}, {N,A}, {R} (eight cycles).
- R5: NEG and ABS occupy {U}, {S}. CMP occupies {U}, {A}, {R}.
- R6: DIV occupies {U}, {A}, {R}, then DIV_D cycles of {D}, then {D,A}, {D,R}, {D,A}, {D,R}, {A}, {R}. That is 9+DIV_D cycles in all.
- R7: A valid legal request is refused (accept low, stall high) exactly when one of its stage bits meets a reserved bit of the same stage in the same cycle. A refused request changes no later busy flag.
- R8: An operation of length L accepted in cycle t raises done in cycle t+L only, with done_tag equal to its issue tag.
- R9: Opcode 7 is never accepted and reserves nothing.
- R10: With in_valid low, accept and stall stay low and nothing is reserved.
- R11: A request whose final cycle would coincide with another operation's final cycle is refused, even if no sub-stage overlaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue request present |
| in_op | input | 3 | Opcode of the request |
| in_tag | input | TAG_W | Sequence tag returned at completion |
| accept | output | 1 | Request taken this cycle |
| stall | output | 1 | Request present but refused |
| busy | output | 8 | Sub-stages in use this cycle |
| done | output | 1 | An operation is in its final cycle |
| done_tag | output | TAG_W | Tag of the completing operation |

## Verification
The assertions assume that in_op is stable and meaningful whenever in_valid is high. They also assume that reset is held low from time zero until the first edges. The stimulus changes inputs only at falling edges and holds reset for several cycles at the start. On a small divide configuration, it issues every opcode as a first operation and every opcode, including the illegal one, as a second request at every offset up to beyond the full pattern length. A bench model of the table, built from the listed patterns, predicts accept, busy, done and tag in every cycle.

// File: rtl/fpsched_pkg.sv
package fpsched_pkg;

    localparam int NSTG  = 8;
    localparam int NRES  = NSTG + 1;
    localparam int RS_U  = 0;
    localparam int RS_S  = 1;
    localparam int RS_A  = 2;
    localparam int RS_R  = 3;
    localparam int RS_E  = 4;
    localparam int RS_M  = 5;
    localparam int RS_N  = 6;
    localparam int RS_D  = 7;
    localparam int RS_W  = 8;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_DIV = 3'd3,
        OP_NEG = 3'd4,
        OP_ABS = 3'd5,
        OP_CMP = 3'd6,
        OP_BAD = 3'd7
    } fpop_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_ACTIVE = 1'b1
    } sched_st_e;

    typedef logic [NRES-1:0] resrow_t;

    // Resources used by operation op in its cycle j (0 = first cycle).
    function automatic resrow_t op_row(input fpop_e op, input int j, input int divd);
        resrow_t r;
        int      t;
        r = '0;
        t = j - (3 + divd);
        case (op)
            OP_ADD, OP_SUB: begin
                case (j)
                    0: r[RS_U] = 1'b1;
                    1: begin r[RS_S] = 1'b1; r[RS_A] = 1'b1; end
                    2: begin r[RS_A] = 1'b1; r[RS_R] = 1'b1; end
                    3: begin r[RS_R] = 1'b1; r[RS_S] = 1'b1; r[RS_W] = 1'b1; end
                    default: r = '0;
                endcase
            end
            OP_MUL: begin
                case (j)
                    0: r[RS_U] = 1'b1;
                    1: begin r[RS_E] = 1'b1; r[RS_M] = 1'b1; end
                    2, 3, 4: r[RS_M] = 1'b1;
                    5: r[RS_N] = 1'b1;
                    6: begin r[RS_N] = 1'b1; r[RS_A] = 1'b1; end
                    7: begin r[RS_R] = 1'b1; r[RS_W] = 1'b1; end
                    default: r = '0;
                endcase
            end
            OP_NEG, OP_ABS: begin
                case (j)
                    0: r[RS_U] = 1'b1;
                    1: begin r[RS_S] = 1'b1; r[RS_W] = 1'b1; end
                    default: r = '0;
                endcase
            end
            OP_CMP: begin
                case (j)
                    0: r[RS_U] = 1'b1;
                    1: r[RS_A] = 1'b1;
                    2: begin r[RS_R] = 1'b1; r[RS_W] = 1'b1; end
                    default: r = '0;
                endcase
            end
            OP_DIV: begin
                if (j == 0) begin
                    r[RS_U] = 1'b1;
                end else if (j == 1) begin
                    r[RS_A] = 1'b1;
                end else if (j == 2) begin
                    r[RS_R] = 1'b1;
                end else if (t < 0) begin
                    r[RS_D] = 1'b1;
                end else begin
                    case (t)
                        0, 2: begin r[RS_D] = 1'b1; r[RS_A] = 1'b1; end
                        1, 3: begin r[RS_D] = 1'b1; r[RS_R] = 1'b1; end
                        4: r[RS_A] = 1'b1;
                        5: begin r[RS_R] = 1'b1; r[RS_W] = 1'b1; end
                        default: r = '0;
                    endcase
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpsched_pattern.sv
module fpsched_pattern
    import fpsched_pkg::*;
#(
    parameter int DIV_D = 28,
    parameter int DEPTH = 9 + DIV_D
) (
    input  fpop_e   op,
    output resrow_t pat [DEPTH]
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        assign pat[g] = op_row(op, g, DIV_D);
    end

endmodule

// File: rtl/fpsched_table.sv
module fpsched_table
    import fpsched_pkg::*;
#(
    parameter int DEPTH = 37
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  resrow_t         pat [DEPTH],
    output logic            hit,
    output logic            pend,
    output logic [NSTG-1:0] busy,
    output logic            done
);

    resrow_t          occ     [DEPTH];
    resrow_t          shifted [DEPTH];
    logic [DEPTH-1:0] clash;
    logic [DEPTH-1:0] rowany;

    for (genvar g = 0; g < DEPTH; g++) begin : g_col
        if (g < DEPTH - 1) begin : g_mid
            assign shifted[g] = occ[g+1];
            assign clash[g]   = |(pat[g] & occ[g+1]);
        end else begin : g_end
            assign shifted[g] = '0;
            assign clash[g]   = 1'b0;
        end
        assign rowany[g] = |occ[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ[g] <= '0;
            end else begin
                occ[g] <= shifted[g] | (take ? pat[g] : '0);
            end
        end
    end

    assign hit  = |clash;
    assign pend = |rowany[DEPTH-1:1];
    assign busy = occ[0][NSTG-1:0];
    assign done = occ[0][RS_W];

endmodule

// File: rtl/fpsched_retire.sv
module fpsched_retire #(
    parameter int DEPTH = 37,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [DEPTH-1:0] wb,
    input  logic [TAG_W-1:0] tag,
    output logic [TAG_W-1:0] done_tag
);

    logic [TAG_W-1:0] tagq [DEPTH];
    logic [TAG_W-1:0] nxt  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g < DEPTH - 1) begin : g_mid
            assign nxt[g] = (take && wb[g]) ? tag : tagq[g+1];
        end else begin : g_end
            assign nxt[g] = (take && wb[g]) ? tag : '0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tagq[g] <= '0;
            end else begin
                tagq[g] <= nxt[g];
            end
        end
    end

    assign done_tag = tagq[0];

endmodule

// File: rtl/fpsched_top.sv
module fpsched_top
    import fpsched_pkg::*;
#(
    parameter int DIV_D = 28,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [TAG_W-1:0] in_tag,
    output logic             accept,
    output logic             stall,
    output logic [7:0]       busy,
    output logic             done,
    output logic [TAG_W-1:0] done_tag
);

    localparam int DEPTH = 9 + DIV_D;

    sched_st_e        state;
    sched_st_e        state_n;
    fpop_e            op;
    resrow_t          pat [DEPTH];
    logic [DEPTH-1:0] wb;
    logic             hit;
    logic             pend;
    logic             legal;

    assign op    = fpop_e'(in_op);
    assign legal = (op != OP_BAD);

    fpsched_pattern #(.DIV_D(DIV_D), .DEPTH(DEPTH)) u_pat (
        .op  (op),
        .pat (pat)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_wb
        assign wb[g] = pat[g][RS_W];
    end

    fpsched_table #(.DEPTH(DEPTH)) u_tab (
        .clk  (clk),
        .rst_n(rst_n),
        .take (accept),
        .pat  (pat),
        .hit  (hit),
        .pend (pend),
        .busy (busy),
        .done (done)
    );

    fpsched_retire #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (accept),
        .wb      (wb),
        .tag     (in_tag),
        .done_tag(done_tag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        accept  = 1'b0;
        state_n = state;
        unique case (state)
            ST_EMPTY: begin
                accept  = in_valid && legal;
                state_n = accept ? ST_ACTIVE : ST_EMPTY;
            end
            ST_ACTIVE: begin
                accept  = in_valid && legal && !hit;
                state_n = (accept || pend) ? ST_ACTIVE : ST_EMPTY;
            end
            default: begin
                accept  = 1'b0;
                state_n = ST_EMPTY;
            end
        endcase
        stall = in_valid && !accept;
    end

endmodule

// File: rtl/fpsched_checker.sv
module fpsched_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [2:0] in_op,
    input logic       accept,
    input logic       stall,
    input logic [7:0] busy,
    input logic       done
);

    AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (in_valid && !accept)); // R7

    AST_BAD_OP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd7) |-> !accept); // R9

    AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!accept && !stall)); // R10

    AST_UNPACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy[0]); // R2

    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy[3] || busy[1])); // R8

endmodule

bind fpsched_top fpsched_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_op   (in_op),
    .accept  (accept),
    .stall   (stall),
    .busy    (busy),
    .done    (done)
);

// File: tb/fpsched_top_test.sv
`timescale 1ns/100ps
module fpsched_top_test;

    localparam int DIVD  = 4;
    localparam int TW    = 4;
    localparam int DEPTH = 9 + DIVD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = 3'd0;
    logic [TW-1:0] in_tag = '0;
    logic          accept, stall, done;
    logic [7:0]    busy;
    logic [TW-1:0] done_tag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [8:0]    m_occ [DEPTH];
    logic [TW-1:0] m_tag [DEPTH];

    always #2.5 clk = ~clk;

    fpsched_top #(.DIV_D(DIVD), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_tag(in_tag), .accept(accept), .stall(stall), .busy(busy),
        .done(done), .done_tag(done_tag)
    );

    // Expected row from the requirement text. Bits: U0 S1 A2 R3 E4 M5 N6 D7, result slot 8.
    function automatic logic [8:0] brow(input int op, input int j);
        logic [8:0] r;
        int len;
        r = '0;
        case (op)
            0, 1: begin
                len = 4;
                if (j == 0) r = 9'h001;
                if (j == 1) r = 9'h006;
                if (j == 2) r = 9'h00C;
                if (j == 3) r = 9'h00A;
            end
            2: begin
                len = 8;
                if (j == 0) r = 9'h001;
                if (j == 1) r = 9'h030;
                if (j >= 2 && j <= 4) r = 9'h020;
                if (j == 5) r = 9'h040;
                if (j == 6) r = 9'h044;
                if (j == 7) r = 9'h008;
            end
            4, 5: begin
                len = 2;
                if (j == 0) r = 9'h001;
                if (j == 1) r = 9'h002;
            end
            6: begin
                len = 3;
                if (j == 0) r = 9'h001;
                if (j == 1) r = 9'h004;
                if (j == 2) r = 9'h008;
            end
            3: begin
                len = 9 + DIVD;
                if (j == 0) r = 9'h001;
                else if (j == 1) r = 9'h004;
                else if (j == 2) r = 9'h008;
                else if (j < 3 + DIVD) r = 9'h080;
                else if (j < len) begin
                    case ((j - 3 - DIVD) % 6)
                        0, 2: r = 9'h084;
                        1, 3: r = 9'h088;
                        4: r = 9'h004;
                        default: r = 9'h008;
                    endcase
                end
            end
            default: len = 0;
        endcase
        if (len > 0 && j == len - 1) r[8] = 1'b1;
        return r;
    endfunction

    function automatic bit m_hit(input int op);
        bit h = 0;
        for (int j = 0; j < DEPTH - 1; j++)
            if ((brow(op, j) & m_occ[j+1]) != 0) h = 1;
        return h;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < DEPTH; k++) begin
            m_occ[k] = '0;
            m_tag[k] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_clear();
        check(busy == 8'h00, "R1", "busy after reset", busy, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
    endtask

    // Called just after a falling edge; returns after the next falling edge.
    task automatic step(input bit v, input int op, input logic [TW-1:0] tg, input string req);
        bit ea;
        in_valid = v;
        in_op = op[2:0];
        in_tag = tg;
        #1;
        ea = v && (op != 7) && !m_hit(op);
        check(accept == ea, req, "accept", accept, ea);
        check(stall == (v && !ea), req, "stall", stall, v && !ea);
        @(posedge clk);
        for (int k = 0; k < DEPTH; k++) begin
            m_occ[k] = (k < DEPTH - 1) ? m_occ[k+1] : '0;
            m_tag[k] = (k < DEPTH - 1) ? m_tag[k+1] : '0;
            if (ea) begin
                m_occ[k] = m_occ[k] | brow(op, k);
                if (brow(op, k) != 0 && brow(op, k) >= 9'h100) m_tag[k] = tg;
            end
        end
        @(negedge clk);
        in_valid = 0;
        check(busy == m_occ[0][7:0], req, "busy", busy, m_occ[0][7:0]);
        check(done == m_occ[0][8], "R8", "done", done, m_occ[0][8]);
        if (m_occ[0][8])
            check(done_tag == m_tag[0], "R8", "done_tag", done_tag, m_tag[0]);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 0, '0, req);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        model_clear();
        do_reset();
        // R1 first legal request accepted; R3 add pattern
        step(1, 0, 4'h1, "R1");
        idle(5, "R3");
        // R2 sub identical to add
        step(1, 1, 4'h2, "R2");
        idle(5, "R2");
        // R4 multiply
        step(1, 2, 4'h3, "R4");
        idle(9, "R4");
        // R5 negate, absolute value, compare
        step(1, 4, 4'h4, "R5");
        idle(3, "R5");
        step(1, 5, 4'h5, "R5");
        idle(3, "R5");
        step(1, 6, 4'h6, "R5");
        idle(4, "R5");
        // R6 divide
        step(1, 3, 4'h7, "R6");
        idle(DEPTH + 1, "R6");
        // R9 illegal opcode leaves table empty
        step(1, 7, 4'h8, "R9");
        idle(2, "R9");
        // R10 no request
        step(0, 2, 4'h9, "R10");
        idle(2, "R10");
        // R11 NEG would finish together with MUL: refused on result slot only
        step(1, 2, 4'hA, "R11");
        idle(5, "R11");
        check(m_hit(4) == 1, "R11", "model expects refusal", 0, 1);
        step(1, 4, 4'hB, "R11");
        idle(DEPTH, "R11");
        // R7 sweep: every first op, every second op, every offset
        for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 8; b++) begin
                for (int d = 0; d <= DEPTH + 1; d++) begin
                    step(1, a, 4'hC, "R7");
                    idle(d, "R7");
                    step(1, b, 4'h3, "R7");
                    idle(DEPTH + 1, "R7");
                end
            end
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule